// File: doc/BRIEF.md
# Dual-Clock Word FIFO with Rewind and Read Skipping

This block is a first-in first-out word buffer. A producer and a consumer sit on two unrelated clocks. Each word is 9 bits wide, and the storage depth is a parameter (512, 1024, 2048, 4096 or 8192 words). Each side has its own active-low enable and its own pointer logic. The two sides exchange only Gray-coded pointer values, and each value passes through a short chain of synchronizing flops. The write side computes the full and almost-full indications. The read side computes the empty and almost-empty indications.

The two "almost" thresholds are held in two offset registers that software-free logic loads through the write port. While the load strobe is low, each enabled write cycle goes to an offset register instead of the memory. The first such write after reset sets the almost-empty offset, and the next one sets the almost-full offset. After that the target keeps alternating.

A rewind strobe on the read side returns the read pointer to location zero, so that everything written since reset can be read again. An output-enable strobe decides whether a read word is presented on the output bus. When output enable is high, a read still consumes a word, but the word is never shown, so stored data can be skipped. The high-impedance state of the bus is modelled as a separate drive-enable output.

Top module: `fifo9_rt`

## Requirements
- R1: Words leave the buffer in the order they were written, with all 9 data bits preserved. The bit patterns 0x000, 0x1FF, 0x155 and 0x0AA are among those checked.
- R2: A word is stored on a rising write-clock edge when `wr_en_n`=0, `load_n`=1 and the buffer is not full. A write attempted while full is dropped: it is not stored and the write pointer does not move.
- R3: A read takes place on a rising read-clock edge when `rd_en_n`=0, `rewind_n`=1 and the buffer is not empty. A read attempted while empty is ignored: the output register keeps its value and the read pointer does not move.
- R4: `full_n` is 0 exactly when DEPTH words are stored, as seen by the write side.
- R5: `empty_n` is 0 when no word is stored. After `rst_n` is released, `empty_n`=0, `almost_empty_n`=0, `full_n`=1, `almost_full_n`=1 and `dout`=0.
- R6: `almost_empty_n` is 0 while the stored count is less than or equal to the almost-empty offset. The offset is 7 after reset.
- R7: `almost_full_n` is 0 while the stored count is at least DEPTH minus the almost-full offset. The offset is 7 after reset.
- R8: A write-clock edge with `load_n`=0 and `wr_en_n`=0 copies `din` into an offset register and leaves the memory and write pointer untouched. The first load after reset sets the almost-empty offset and the second sets the almost-full offset, after which the target alternates.
- R9: While `oe_n`=1, `dout_en`=0 and `dout` reads 0. A read made while `oe_n`=1 consumes its word without capturing it, so the output register keeps the previously presented word.
- R10: A read-clock edge with `rewind_n`=0 sets the read pointer to location zero, with priority over a read. Reading then starts again from the first word written since reset.
- R11: Each side learns the other side's pointer through Gray code. Apart from a rewind, each Gray pointer changes by at most one bit per clock. The flags on each side follow the far side's progress within a few of their own clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Free-running write-side clock |
| rd_clk | input | 1 | Free-running read-side clock |
| rst_n | input | 1 | Master reset, active low, asynchronous to both sides |
| wr_en_n | input | 1 | Write enable, active low |
| rd_en_n | input | 1 | Read enable, active low |
| load_n | input | 1 | Redirects enabled writes to the offset registers when low |
| oe_n | input | 1 | Output enable, active low; when high, reads are skipped |
| rewind_n | input | 1 | Rewinds the read pointer to zero when low |
| din | input | 9 | Write data, or the offset value during a load |
| dout | output | 9 | Read data; 0 while not driven |
| dout_en | output | 1 | High when the output bus is driven |
| full_n | output | 1 | Full flag, active low (write side) |
| empty_n | output | 1 | Empty flag, active low (read side) |
| almost_full_n | output | 1 | Almost-full flag, active low (write side) |
| almost_empty_n | output | 1 | Almost-empty flag, active low (read side) |

## Verification
On every cycle, the assertions check the following:
- A write refused while full, and a load cycle, both leave the write pointer in place.
- A read refused while empty leaves the read pointer in place.
- A rewind always lands the read pointer on zero.
- A skipped read leaves the output register unchanged.
- The bus reads zero and is undriven while output enable is high.
- Each Gray pointer moves by a single bit at most.
- The write-side count never exceeds the depth.

Only the directed scenarios can show the rest:
- Word order and data integrity.
- The exact stored counts at which each flag changes, under both default and loaded offsets.
- The alternating target of the load sequence.
- That a rewound buffer replays the same words.

// File: rtl/fifo9_pkg.sv
package fifo9_pkg;

  typedef logic [15:0] ptr16_t;

  typedef enum logic {
    SEL_EMPTY_OFF = 1'b0,
    SEL_FULL_OFF  = 1'b1
  } load_sel_e;

  function automatic ptr16_t bin2gray(input ptr16_t b);
    return b ^ (b >> 1);
  endfunction

  function automatic ptr16_t gray2bin(input ptr16_t g);
    ptr16_t b;
    b[15] = g[15];
    for (int i = 14; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  function automatic logic near_full(input int level, input int depth, input int off);
    return level >= (depth - off);
  endfunction

  function automatic logic near_empty(input int level, input int off);
    return level <= off;
  endfunction

endpackage

// File: rtl/fifo9_sync.sv
module fifo9_sync #(
  parameter int W      = 10,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stg [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[s] <= '0;
        else        stg[s] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[s] <= '0;
        else        stg[s] <= stg[s-1];
      end
    end
  end

  assign q = stg[STAGES-1];

endmodule

// File: rtl/fifo9_mem.sv
module fifo9_mem #(
  parameter int WIDTH = 9,
  parameter int DEPTH = 512
) (
  input  logic                     wr_clk,
  input  logic                     we,
  input  logic [$clog2(DEPTH)-1:0] waddr,
  input  logic [WIDTH-1:0]         wdata,
  input  logic                     rd_clk,
  input  logic                     rst_n,
  input  logic                     re,
  input  logic [$clog2(DEPTH)-1:0] raddr,
  output logic [WIDTH-1:0]         rdata
);

  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge wr_clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge rd_clk or negedge rst_n) begin
    if (!rst_n)  rdata <= '0;
    else if (re) rdata <= mem[raddr];
  end

endmodule

// File: rtl/fifo9_wr_ctrl.sv
module fifo9_wr_ctrl
  import fifo9_pkg::*;
#(
  parameter int WIDTH      = 9,
  parameter int DEPTH      = 512,
  parameter int DEF_OFFSET = 7
) (
  input  logic                     wr_clk,
  input  logic                     rst_n,
  input  logic                     wr_en_n,
  input  logic                     load_n,
  input  logic [WIDTH-1:0]         din,
  input  logic [$clog2(DEPTH):0]   rgray_s,
  output logic                     we,
  output logic [$clog2(DEPTH)-1:0] waddr,
  output logic [$clog2(DEPTH):0]   wgray,
  output logic [$clog2(DEPTH):0]   wptr,
  output logic [$clog2(DEPTH):0]   level,
  output logic                     full_n,
  output logic                     almost_full_n,
  output logic                     load_fire,
  output logic [WIDTH-1:0]         ae_off
);

  localparam int AW = $clog2(DEPTH);
  localparam int PW = AW + 1;

  logic [PW-1:0]    rptr_w;
  logic [PW-1:0]    wptr_nx;
  logic [WIDTH-1:0] af_off;
  logic             full;
  load_sel_e        sel;

  assign rptr_w    = PW'(gray2bin(16'(rgray_s)));
  assign level     = wptr - rptr_w;
  assign full      = (level == PW'(DEPTH));
  assign we        = !wr_en_n && load_n && !full;
  assign load_fire = !wr_en_n && !load_n;
  assign wptr_nx   = wptr + 1'b1;
  assign waddr     = wptr[AW-1:0];

  assign full_n        = !full;
  assign almost_full_n = !near_full(int'(level), DEPTH, int'(af_off));

  always_ff @(posedge wr_clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr  <= '0;
      wgray <= '0;
    end else if (we) begin
      wptr  <= wptr_nx;
      wgray <= PW'(bin2gray(16'(wptr_nx)));
    end
  end

  always_ff @(posedge wr_clk or negedge rst_n) begin
    if (!rst_n) begin
      ae_off <= WIDTH'(DEF_OFFSET);
      af_off <= WIDTH'(DEF_OFFSET);
      sel    <= SEL_EMPTY_OFF;
    end else if (load_fire) begin
      if (sel == SEL_EMPTY_OFF) begin
        ae_off <= din;
        sel    <= SEL_FULL_OFF;
      end else begin
        af_off <= din;
        sel    <= SEL_EMPTY_OFF;
      end
    end
  end

endmodule

// File: rtl/fifo9_rd_ctrl.sv
module fifo9_rd_ctrl
  import fifo9_pkg::*;
#(
  parameter int WIDTH = 9,
  parameter int DEPTH = 512
) (
  input  logic                     rd_clk,
  input  logic                     rst_n,
  input  logic                     rd_en_n,
  input  logic                     oe_n,
  input  logic                     rewind_n,
  input  logic [$clog2(DEPTH):0]   wgray_s,
  input  logic [WIDTH-1:0]         ae_off,
  output logic                     capture,
  output logic                     skip,
  output logic [$clog2(DEPTH)-1:0] raddr,
  output logic [$clog2(DEPTH):0]   rgray,
  output logic [$clog2(DEPTH):0]   rptr,
  output logic                     empty_n,
  output logic                     almost_empty_n
);

  localparam int AW = $clog2(DEPTH);
  localparam int PW = AW + 1;

  logic [PW-1:0] wptr_r;
  logic [PW-1:0] level;
  logic [PW-1:0] rptr_nx;
  logic          empty;
  logic          rd_fire;

  assign wptr_r  = PW'(gray2bin(16'(wgray_s)));
  assign level   = wptr_r - rptr;
  assign empty   = (level == '0);
  assign rd_fire = !rd_en_n && rewind_n && !empty;
  assign capture = rd_fire && !oe_n;
  assign skip    = rd_fire && oe_n;
  assign raddr   = rptr[AW-1:0];

  assign empty_n        = !empty;
  assign almost_empty_n = !near_empty(int'(level), int'(ae_off));

  always_comb begin
    rptr_nx = rptr;
    if (!rewind_n)    rptr_nx = '0;
    else if (rd_fire) rptr_nx = rptr + 1'b1;
  end

  always_ff @(posedge rd_clk or negedge rst_n) begin
    if (!rst_n) begin
      rptr  <= '0;
      rgray <= '0;
    end else begin
      rptr  <= rptr_nx;
      rgray <= PW'(bin2gray(16'(rptr_nx)));
    end
  end

endmodule

// File: rtl/fifo9_rt.sv
module fifo9_rt #(
  parameter int WIDTH       = 9,
  parameter int DEPTH       = 512,
  parameter int SYNC_STAGES = 2,
  parameter int DEF_OFFSET  = 7
) (
  input  logic             wr_clk,
  input  logic             rd_clk,
  input  logic             rst_n,
  input  logic             wr_en_n,
  input  logic             rd_en_n,
  input  logic             load_n,
  input  logic             oe_n,
  input  logic             rewind_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout,
  output logic             dout_en,
  output logic             full_n,
  output logic             empty_n,
  output logic             almost_full_n,
  output logic             almost_empty_n
);

  localparam int AW = $clog2(DEPTH);
  localparam int PW = AW + 1;

  logic          we, capture, skip, load_fire;
  logic [AW-1:0] waddr, raddr;
  logic [PW-1:0] wgray, rgray, wgray_s, rgray_s;
  logic [PW-1:0] wptr, rptr, wr_level;
  logic [WIDTH-1:0] ae_off, dout_q;

  fifo9_wr_ctrl #(.WIDTH(WIDTH), .DEPTH(DEPTH), .DEF_OFFSET(DEF_OFFSET)) u_wr (
    .wr_clk(wr_clk), .rst_n(rst_n), .wr_en_n(wr_en_n), .load_n(load_n),
    .din(din), .rgray_s(rgray_s), .we(we), .waddr(waddr), .wgray(wgray),
    .wptr(wptr), .level(wr_level), .full_n(full_n),
    .almost_full_n(almost_full_n), .load_fire(load_fire), .ae_off(ae_off)
  );

  fifo9_rd_ctrl #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_rd (
    .rd_clk(rd_clk), .rst_n(rst_n), .rd_en_n(rd_en_n), .oe_n(oe_n),
    .rewind_n(rewind_n), .wgray_s(wgray_s), .ae_off(ae_off),
    .capture(capture), .skip(skip), .raddr(raddr), .rgray(rgray),
    .rptr(rptr), .empty_n(empty_n), .almost_empty_n(almost_empty_n)
  );

  fifo9_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_w2r (
    .clk(rd_clk), .rst_n(rst_n), .d(wgray), .q(wgray_s)
  );

  fifo9_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_r2w (
    .clk(wr_clk), .rst_n(rst_n), .d(rgray), .q(rgray_s)
  );

  fifo9_mem #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_mem (
    .wr_clk(wr_clk), .we(we), .waddr(waddr), .wdata(din),
    .rd_clk(rd_clk), .rst_n(rst_n), .re(capture), .raddr(raddr),
    .rdata(dout_q)
  );

  assign dout_en = !oe_n;
  assign dout    = dout_en ? dout_q : '0;

endmodule

// File: rtl/fifo9_rt_chk.sv
module fifo9_rt_chk #(
  parameter int WIDTH = 9,
  parameter int DEPTH = 512,
  parameter int PW    = 10
) (
  input logic             wr_clk,
  input logic             rd_clk,
  input logic             rst_n,
  input logic             wr_en_n,
  input logic             rd_en_n,
  input logic             load_n,
  input logic             oe_n,
  input logic             rewind_n,
  input logic             full_n,
  input logic             empty_n,
  input logic             dout_en,
  input logic [WIDTH-1:0] dout,
  input logic [WIDTH-1:0] dout_q,
  input logic             skip,
  input logic [PW-1:0]    wptr,
  input logic [PW-1:0]    rptr,
  input logic [PW-1:0]    wgray,
  input logic [PW-1:0]    rgray,
  input logic [PW-1:0]    wr_level
);

  // R2: a write refused for fullness leaves the write pointer in place
  assert_full_hold_R2: assert property (@(posedge wr_clk) disable iff (!rst_n)
    (!full_n && !wr_en_n && load_n) |=> (wptr == $past(wptr)));

  // R4: the write side never counts more than DEPTH stored words
  assert_no_overflow_R4: assert property (@(posedge wr_clk) disable iff (!rst_n)
    (int'(wr_level) <= DEPTH));

  // R3: a read refused for emptiness leaves the read pointer in place
  assert_empty_hold_R3: assert property (@(posedge rd_clk) disable iff (!rst_n)
    (!empty_n && !rd_en_n && rewind_n) |=> (rptr == $past(rptr)));

  // R8: a load cycle never advances the write pointer
  assert_load_nowrite_R8: assert property (@(posedge wr_clk) disable iff (!rst_n)
    (!load_n && !wr_en_n) |=> $stable(wptr));

  // R9: a skipped read does not disturb the output register
  assert_skip_hold_R9: assert property (@(posedge rd_clk) disable iff (!rst_n)
    skip |=> $stable(dout_q));

  // R9: bus undriven and zero while output enable is high
  assert_hiz_R9: assert property (@(posedge rd_clk) disable iff (!rst_n)
    oe_n |-> (!dout_en && dout == '0));

  // R10: rewind lands the read pointer on zero
  assert_rewind_R10: assert property (@(posedge rd_clk) disable iff (!rst_n)
    !rewind_n |=> (rptr == '0));

  // R11: write-side Gray pointer moves one bit at most
  assert_wgray_step_R11: assert property (@(posedge wr_clk) disable iff (!rst_n)
    1'b1 |=> ($countones(wgray ^ $past(wgray)) <= 1));

  // R11: read-side Gray pointer moves one bit at most except after a rewind
  assert_rgray_step_R11: assert property (@(posedge rd_clk) disable iff (!rst_n)
    rewind_n |=> ($countones(rgray ^ $past(rgray)) <= 1));

endmodule

bind fifo9_rt fifo9_rt_chk #(.WIDTH(WIDTH), .DEPTH(DEPTH), .PW(PW)) u_chk (
  .wr_clk(wr_clk), .rd_clk(rd_clk), .rst_n(rst_n), .wr_en_n(wr_en_n),
  .rd_en_n(rd_en_n), .load_n(load_n), .oe_n(oe_n), .rewind_n(rewind_n),
  .full_n(full_n), .empty_n(empty_n), .dout_en(dout_en), .dout(dout),
  .dout_q(dout_q), .skip(skip), .wptr(wptr), .rptr(rptr), .wgray(wgray),
  .rgray(rgray), .wr_level(wr_level)
);

// File: tb/sim_fifo9_rt.sv
`timescale 1ns/1ps
module sim_fifo9_rt;

  localparam int DEPTH = 512;

  logic wr_clk = 1'b0, rd_clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en_n = 1'b1, rd_en_n = 1'b1, load_n = 1'b1, oe_n = 1'b0, rewind_n = 1'b1;
  logic [8:0] din = '0;
  logic [8:0] dout;
  logic dout_en, full_n, empty_n, almost_full_n, almost_empty_n;

  int checks = 0;
  int fails  = 0;

  always #2 wr_clk = ~wr_clk;
  initial begin
    #1;
    forever #2 rd_clk = ~rd_clk;
  end

  fifo9_rt #(.DEPTH(DEPTH)) u0 (
    .wr_clk(wr_clk), .rd_clk(rd_clk), .rst_n(rst_n), .wr_en_n(wr_en_n),
    .rd_en_n(rd_en_n), .load_n(load_n), .oe_n(oe_n), .rewind_n(rewind_n),
    .din(din), .dout(dout), .dout_en(dout_en), .full_n(full_n),
    .empty_n(empty_n), .almost_full_n(almost_full_n),
    .almost_empty_n(almost_empty_n)
  );

  function automatic logic [8:0] pat(input int i);
    return 9'((i * 37 + 5) ^ 9'h0A5);
  endfunction

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  task automatic settle();
    repeat (6) @(negedge wr_clk);
    repeat (6) @(negedge rd_clk);
  endtask

  task automatic do_reset();
    @(negedge wr_clk);
    rst_n = 1'b0; wr_en_n = 1'b1; rd_en_n = 1'b1; load_n = 1'b1;
    oe_n = 1'b0; rewind_n = 1'b1; din = '0;
    repeat (3) @(negedge wr_clk);
    rst_n = 1'b1;
    settle();
  endtask

  task automatic wr(input logic [8:0] d);
    @(negedge wr_clk);
    din = d; wr_en_n = 1'b0;
    @(negedge wr_clk);
    wr_en_n = 1'b1;
  endtask

  task automatic rd(output logic [8:0] d);
    @(negedge rd_clk);
    rd_en_n = 1'b0;
    @(negedge rd_clk);
    rd_en_n = 1'b1;
    d = dout;
  endtask

  task automatic t_reset_state();
    do_reset();
    chk("R5", "empty_n after reset", int'(empty_n), 0);
    chk("R5", "almost_empty_n after reset", int'(almost_empty_n), 0);
    chk("R5", "full_n after reset", int'(full_n), 1);
    chk("R5", "almost_full_n after reset", int'(almost_full_n), 1);
    chk("R5", "dout after reset", int'(dout), 0);
  endtask

  task automatic t_order();
    logic [8:0] v [6];
    logic [8:0] got;
    do_reset();
    v[0] = 9'h000; v[1] = 9'h1FF; v[2] = 9'h155; v[3] = 9'h0AA; v[4] = 9'h101; v[5] = 9'h0FE;
    for (int i = 0; i < 6; i++) wr(v[i]);
    settle();
    chk("R5", "empty_n with data", int'(empty_n), 1);
    for (int i = 0; i < 6; i++) begin
      rd(got);
      chk("R1", "word order", int'(got), int'(v[i]));
    end
    chk("R5", "empty_n after drain", int'(empty_n), 0);
  endtask

  task automatic t_empty_read();
    logic [8:0] got;
    do_reset();
    rd(got);
    chk("R3", "dout after read of empty buffer", int'(got), 0);
    wr(9'h055);
    settle();
    rd(got);
    chk("R3", "first word after ignored read", int'(got), 9'h055);
    chk("R3", "empty after single word", int'(empty_n), 0);
  endtask

  task automatic t_fill_full();
    logic [8:0] got;
    int bad;
    do_reset();
    for (int i = 0; i < DEPTH - 8; i++) wr(pat(i));
    settle();
    chk("R7", "almost_full_n at DEPTH-8", int'(almost_full_n), 1);
    wr(pat(DEPTH - 8));
    settle();
    chk("R7", "almost_full_n at DEPTH-7", int'(almost_full_n), 0);
    for (int i = DEPTH - 7; i < DEPTH - 1; i++) wr(pat(i));
    settle();
    chk("R4", "full_n at DEPTH-1", int'(full_n), 1);
    wr(pat(DEPTH - 1));
    settle();
    chk("R4", "full_n at DEPTH", int'(full_n), 0);
    wr(9'h1FF);
    settle();
    rd(got);
    chk("R1", "first word of full buffer", int'(got), int'(pat(0)));
    settle();
    chk("R11", "full_n clears once read seen by write side", int'(full_n), 1);
    bad = 0;
    for (int i = 1; i < DEPTH; i++) begin
      rd(got);
      if (got != pat(i)) bad++;
    end
    chk("R1", "mismatches over full drain", bad, 0);
    chk("R2", "empty after DEPTH reads (extra write dropped)", int'(empty_n), 0);
  endtask

  task automatic t_almost_empty();
    do_reset();
    for (int i = 0; i < 7; i++) wr(pat(i));
    settle();
    chk("R6", "almost_empty_n with 7 words", int'(almost_empty_n), 0);
    wr(pat(7));
    settle();
    chk("R6", "almost_empty_n with 8 words", int'(almost_empty_n), 1);
  endtask

  task automatic t_load_offsets();
    logic [8:0] got;
    do_reset();
    @(negedge wr_clk) load_n = 1'b0;
    wr(9'd3);
    wr(9'd5);
    @(negedge wr_clk) load_n = 1'b1;
    settle();
    chk("R8", "empty_n after load cycles", int'(empty_n), 0);
    for (int i = 0; i < 3; i++) wr(pat(i));
    settle();
    chk("R8", "almost_empty_n with 3 words, offset 3", int'(almost_empty_n), 0);
    wr(pat(3));
    settle();
    chk("R8", "almost_empty_n with 4 words, offset 3", int'(almost_empty_n), 1);
    rd(got);
    chk("R8", "first word is data, not offset", int'(got), int'(pat(0)));
    for (int i = 4; i < DEPTH - 5; i++) wr(pat(i));
    settle();
    chk("R8", "almost_full_n one below DEPTH-5", int'(almost_full_n), 1);
    wr(pat(DEPTH - 5));
    settle();
    chk("R8", "almost_full_n at DEPTH-5", int'(almost_full_n), 0);
  endtask

  task automatic t_skip();
    logic [8:0] got;
    do_reset();
    wr(9'h1A1); wr(9'h1B2); wr(9'h1C3);
    settle();
    rd(got);
    chk("R9", "presented word", int'(got), 9'h1A1);
    chk("R9", "dout_en with oe_n low", int'(dout_en), 1);
    @(negedge rd_clk) oe_n = 1'b1;
    @(negedge rd_clk);
    chk("R9", "dout_en with oe_n high", int'(dout_en), 0);
    chk("R9", "dout with oe_n high", int'(dout), 0);
    rd(got);
    chk("R9", "dout during skipped read", int'(got), 0);
    @(negedge rd_clk) oe_n = 1'b0;
    @(negedge rd_clk);
    chk("R9", "output holds word before skip", int'(dout), 9'h1A1);
    rd(got);
    chk("R9", "word after skipped one", int'(got), 9'h1C3);
    chk("R9", "skipped word was consumed", int'(empty_n), 0);
  endtask

  task automatic t_rewind();
    logic [8:0] got;
    do_reset();
    for (int i = 0; i < 4; i++) wr(9'h010 + 9'(i));
    settle();
    for (int i = 0; i < 4; i++) rd(got);
    chk("R10", "empty before rewind", int'(empty_n), 0);
    @(negedge rd_clk) begin rewind_n = 1'b0; rd_en_n = 1'b0; end
    @(negedge rd_clk) begin rewind_n = 1'b1; rd_en_n = 1'b1; end
    chk("R10", "empty_n after rewind", int'(empty_n), 1);
    for (int i = 0; i < 4; i++) begin
      rd(got);
      chk("R10", "replayed word", int'(got), 9'h010 + i);
    end
    chk("R10", "empty after replay", int'(empty_n), 0);
  endtask

  initial begin
    t_reset_state();
    t_order();
    t_empty_read();
    t_fill_full();
    t_almost_empty();
    t_load_offsets();
    t_skip();
    t_rewind();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #400000;
    checks++;
    fails++;
    $display("FAIL watchdog: actual=expired expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule